// File: doc/BRIEF.md
# Wideband Lambda Sensor Heater Warm-Up Sequencer

This block brings the heater of one wideband lambda sensor from cold to its regulated operating point. It first waits for a healthy supply and for the sensor interface to report that calibration is finished. It then applies a low effective voltage for a fixed time, so that any water in the exhaust can evaporate without cracking the ceramic. After that it raises the effective voltage along a slew-limited ramp. Only when the ramp is complete does it pass heater control to an external closed-loop regulator. A chip with two sensor banks uses two instances.

The state logic advances only on every tenth pulse of a 10 ms tick, so once every 100 ms. The heater drive is a PWM signal whose period equals one tick interval, 100 Hz by default. Each heater target is an effective (RMS) voltage in millivolts. The block turns it into PWM duty using the measured battery voltage. A diagnostic fault from any state stops heating at once and holds the block in an error state until a synchronous restart.

Top module: `htr_warmup_seq`

## Requirements
- R1: After reset the state code is 0 (idle), `valid_o` is 0 and `heater_o` stays low.
- R2: State codes on `state_o` are idle 0, wait-for-power 1, calibrating 2, condensation 3, ramp 4, regulation 5 and error 7. The normal path visits them in that order. Idle moves to wait-for-power at the first evaluation.
- R3: State moves other than those caused by fault or restart happen only at an evaluation. An evaluation is every tenth `tick_i` pulse counted from reset. `restart_i` does not change this count.
- R4: Wait-for-power moves to calibrating only at an evaluation where `vbat_mv_i` is strictly greater than 11000 mV. At exactly 11000 mV it stays in wait-for-power.
- R5: Calibrating moves to condensation at an evaluation where `cal_done_i` is 1, and otherwise stays in calibrating.
- R6: Condensation targets 2000 mV effective. It lasts 50 evaluations (5 s): the 50th evaluation after entry moves to ramp.
- R7: Ramp starts at 8500 mV. Each evaluation adds 40 mV, with the value capped at 13000 mV. The first evaluation that finds 13000 mV moves to regulation, which is the 114th evaluation after entry.
- R8: Duty in PWM steps equals floor(target² × STEPS / vbat²), clamped to STEPS (100 by default). Duty is 0 in idle, wait-for-power, calibrating and error.
- R9: The PWM frame is STEPS × CLK_PER_STEP clocks. The duty is sampled at the start of each frame, and the output is high for duty steps of each frame.
- R10: `valid_o` is 1 only in regulation, and it rises only when leaving ramp.
- R11: In regulation the duty is `reg_duty_i`, clamped to STEPS.
- R12: A diagnostic fault in any state moves the block to error on the next clock, without waiting for an evaluation. In error `heater_o` is held low.
- R13: Error is left only through `restart_i`, which moves any state to idle on the next clock and takes priority over a fault in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous return to idle |
| tick_i | input | 1 | One-clock pulse every 10 ms |
| vbat_mv_i | input | V_W | Battery voltage in millivolts |
| cal_done_i | input | 1 | Sensor calibration finished |
| diag_fault_i | input | 1 | Diagnostic failure |
| reg_duty_i | input | DUTY_W | Duty request from the closed-loop regulator, in PWM steps |
| heater_o | output | 1 | Heater PWM drive |
| state_o | output | 3 | Sequencer state code |
| valid_o | output | 1 | Sensor readings valid |

## Verification
The duty conversion is driven with a battery voltage well above the target, which gives small fractional duties that test truncation. It is also driven with a battery voltage below the target, which must saturate, and with the ramp end point against a lower supply. Regulator requests below and above full scale separate the pass-through path from the clamp. State timing is probed on both sides of each decision: the ninth tick against the tenth, exactly 11 V against 11.001 V, the 49th condensation evaluation against the 50th, and the 113th ramp evaluation against the 114th. A fault is applied both during regulation and in idle, and a restart is applied while a fault is active, to show that error is entered without decimation and left only through restart.

// File: rtl/htr_pkg.sv
package htr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_CAL  = 3'd2,
        ST_COND = 3'd3,
        ST_RAMP = 3'd4,
        ST_REG  = 3'd5,
        ST_ERR  = 3'd7
    } htr_state_e;

endpackage

// File: rtl/htr_decim.sv
module htr_decim #(
    parameter int DECIM = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic eval_o
);
    localparam int DW = $clog2(DECIM + 1);

    logic [DW-1:0] cnt_d, cnt_q;
    logic          last;

    always_comb begin
        last  = (cnt_q == DW'(DECIM - 1));
        cnt_d = cnt_q;
        if (tick_i) cnt_d = last ? '0 : DW'(cnt_q + 1'b1);
        eval_o = tick_i && last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the phase counter never leaves its range
    p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DW'(DECIM - 1));

endmodule

// File: rtl/htr_duty_calc.sv
module htr_duty_calc #(
    parameter int V_W       = 16,
    parameter int PWM_STEPS = 100,
    localparam int DUTY_W   = $clog2(PWM_STEPS + 1)
) (
    input  logic [V_W-1:0]    target_mv_i,
    input  logic [V_W-1:0]    vbat_mv_i,
    input  logic              use_reg_i,
    input  logic [DUTY_W-1:0] reg_duty_i,
    output logic [DUTY_W-1:0] duty_o
);
    localparam int PW = 2 * V_W + DUTY_W;

    logic [PW-1:0] t_w, b_w, num, den, lim;

    always_comb begin
        t_w = PW'(target_mv_i);
        b_w = PW'(vbat_mv_i);
        num = t_w * t_w * PW'(PWM_STEPS);
        den = b_w * b_w;
        lim = den * PW'(PWM_STEPS);
        if (use_reg_i)
            duty_o = (reg_duty_i > DUTY_W'(PWM_STEPS)) ? DUTY_W'(PWM_STEPS) : reg_duty_i;
        else if (num == '0)
            duty_o = '0;
        else if (num >= lim)
            duty_o = DUTY_W'(PWM_STEPS);
        else
            duty_o = DUTY_W'(num / den);
    end

endmodule

// File: rtl/htr_pwm.sv
module htr_pwm #(
    parameter int PWM_STEPS    = 100,
    parameter int CLK_PER_STEP = 12500,
    localparam int DUTY_W      = $clog2(PWM_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pwm_o
);
    localparam int DIV_W = $clog2(CLK_PER_STEP + 1);

    logic [DIV_W-1:0]  div_d, div_q;
    logic [DUTY_W-1:0] pos_d, pos_q;
    logic [DUTY_W-1:0] duty_d, duty_q;
    logic              step_end, frame_end;

    always_comb begin
        step_end  = (div_q == DIV_W'(CLK_PER_STEP - 1));
        frame_end = step_end && (pos_q == DUTY_W'(PWM_STEPS - 1));
        div_d     = step_end ? '0 : DIV_W'(div_q + 1'b1);
        pos_d     = pos_q;
        if (step_end) pos_d = frame_end ? '0 : DUTY_W'(pos_q + 1'b1);
        duty_d    = frame_end ? duty_i : duty_q;
        pwm_o     = (pos_q < duty_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            pos_q  <= '0;
            duty_q <= '0;
        end else begin
            div_q  <= div_d;
            pos_q  <= pos_d;
            duty_q <= duty_d;
        end
    end

    // R9: duty only changes at a frame boundary
    p_duty_at_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty_q) |-> (pos_q == '0 && div_q == '0));

endmodule

// File: rtl/htr_warmup_seq.sv
module htr_warmup_seq
    import htr_pkg::*;
#(
    parameter int V_W           = 16,
    parameter int PWM_STEPS     = 100,
    parameter int CLK_PER_STEP  = 12500,
    parameter int DECIM         = 10,
    parameter int WAKE_MV       = 11000,
    parameter int COND_MV       = 2000,
    parameter int COND_EVALS    = 50,
    parameter int RAMP_START_MV = 8500,
    parameter int RAMP_END_MV   = 13000,
    parameter int RAMP_STEP_MV  = 40,
    localparam int DUTY_W       = $clog2(PWM_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              tick_i,
    input  logic [V_W-1:0]    vbat_mv_i,
    input  logic              cal_done_i,
    input  logic              diag_fault_i,
    input  logic [DUTY_W-1:0] reg_duty_i,
    output logic              heater_o,
    output logic [2:0]        state_o,
    output logic              valid_o
);
    localparam int CNT_W = $clog2(COND_EVALS + 1);

    typedef struct packed {
        htr_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [V_W-1:0]   ramp;
    } seq_t;

    seq_t              seq_d, seq_q;
    logic              eval;
    logic [V_W:0]      ramp_sum;
    logic [V_W-1:0]    tgt_mv;
    logic              use_reg;
    logic [DUTY_W-1:0] duty;
    logic              pwm_on;

    htr_decim #(.DECIM(DECIM)) u_decim (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .eval_o (eval)
    );

    // next-state logic
    always_comb begin
        seq_d    = seq_q;
        ramp_sum = {1'b0, seq_q.ramp} + (V_W+1)'(RAMP_STEP_MV);
        if (restart_i) begin
            seq_d.st   = ST_IDLE;
            seq_d.cnt  = '0;
            seq_d.ramp = '0;
        end else if (diag_fault_i) begin
            seq_d.st = ST_ERR;
        end else if (eval) begin
            case (seq_q.st)
                ST_IDLE: seq_d.st = ST_WAIT;
                ST_WAIT: if (vbat_mv_i > V_W'(WAKE_MV)) seq_d.st = ST_CAL;
                ST_CAL: if (cal_done_i) begin
                    seq_d.st  = ST_COND;
                    seq_d.cnt = '0;
                end
                ST_COND: if (seq_q.cnt == CNT_W'(COND_EVALS - 1)) begin
                    seq_d.st   = ST_RAMP;
                    seq_d.ramp = V_W'(RAMP_START_MV);
                end else begin
                    seq_d.cnt = CNT_W'(seq_q.cnt + 1'b1);
                end
                ST_RAMP: if (seq_q.ramp >= V_W'(RAMP_END_MV)) begin
                    seq_d.st = ST_REG;
                end else if (ramp_sum >= (V_W+1)'(RAMP_END_MV)) begin
                    seq_d.ramp = V_W'(RAMP_END_MV);
                end else begin
                    seq_d.ramp = V_W'(ramp_sum);
                end
                default: seq_d = seq_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.cnt  <= '0;
            seq_q.ramp <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // heater target per state
    always_comb begin
        tgt_mv  = '0;
        use_reg = 1'b0;
        case (seq_q.st)
            ST_COND: tgt_mv  = V_W'(COND_MV);
            ST_RAMP: tgt_mv  = seq_q.ramp;
            ST_REG:  use_reg = 1'b1;
            default: tgt_mv  = '0;
        endcase
    end

    htr_duty_calc #(.V_W(V_W), .PWM_STEPS(PWM_STEPS)) u_duty (
        .target_mv_i (tgt_mv),
        .vbat_mv_i   (vbat_mv_i),
        .use_reg_i   (use_reg),
        .reg_duty_i  (reg_duty_i),
        .duty_o      (duty)
    );

    htr_pwm #(.PWM_STEPS(PWM_STEPS), .CLK_PER_STEP(CLK_PER_STEP)) u_pwm (
        .clk    (clk),
        .rst_n  (rst_n),
        .duty_i (duty),
        .pwm_o  (pwm_on)
    );

    assign heater_o = pwm_on && (seq_q.st != ST_ERR);
    assign state_o  = seq_q.st;
    assign valid_o  = (seq_q.st == ST_REG);

    p_fault_to_error_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_fault_i && !restart_i) |=> (seq_q.st == ST_ERR));

    p_error_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_ERR && !restart_i) |=> (seq_q.st == ST_ERR));

    p_restart_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (seq_q.st == ST_IDLE));

    p_wake_threshold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_CAL && $past(seq_q.st) == ST_WAIT)
            |-> ($past(vbat_mv_i) > V_W'(WAKE_MV)));

    p_ramp_monotonic_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_RAMP && $past(seq_q.st) == ST_RAMP)
            |-> (seq_q.ramp >= $past(seq_q.ramp) && seq_q.ramp <= V_W'(RAMP_END_MV)));

    p_valid_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> ($past(seq_q.st) == ST_RAMP));

    p_eval_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !diag_fault_i && !eval) |=> $stable(seq_q.st));

endmodule

// File: tb/htr_warmup_seq_tb.sv
module htr_warmup_seq_tb_top;

    localparam int DUTY_W = 7;
    localparam int TICK_CLKS = 25;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              restart = 1'b0;
    logic              tick = 1'b0;
    logic [15:0]       vbat = 16'd11000;
    logic              cal_done = 1'b0;
    logic              fault = 1'b0;
    logic [DUTY_W-1:0] reg_duty = '0;
    logic              heater;
    logic [2:0]        state;
    logic              valid;

    int checks = 0;
    int errors = 0;
    int tick_total = 0;
    int div = 0;

    always #4 clk = ~clk;

    htr_warmup_seq #(.CLK_PER_STEP(1)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_i    (restart),
        .tick_i       (tick),
        .vbat_mv_i    (vbat),
        .cal_done_i   (cal_done),
        .diag_fault_i (fault),
        .reg_duty_i   (reg_duty),
        .heater_o     (heater),
        .state_o      (state),
        .valid_o      (valid)
    );

    // tick source: one pulse every TICK_CLKS clocks, counted from reset release
    always @(negedge clk) begin
        if (!rst_n) begin
            div <= 0; tick <= 1'b0; tick_total <= 0;
        end else if (div == TICK_CLKS - 1) begin
            div <= 0; tick <= 1'b1; tick_total <= tick_total + 1;
        end else begin
            div <= div + 1; tick <= 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_eval();
        int tgt = ((tick_total / 10) + 1) * 10;
        wait (tick_total == tgt);
        @(negedge clk);
    endtask

    task automatic meas(output int n);
        n = 0;
        repeat (110) @(negedge clk);
        repeat (100) begin
            @(negedge clk);
            if (heater) n++;
        end
    endtask

    task automatic t_reset();
        int n;
        chk("R1 state", int'(state), 0);
        chk("R1 valid", int'(valid), 0);
        meas(n);
        chk("R1 R8 heater idle", n, 0);
    endtask

    task automatic t_wake();
        int n;
        wait (tick_total == 9);
        @(negedge clk); @(negedge clk);
        chk("R3 no move before tenth tick", int'(state), 0);
        wait_eval();
        chk("R2 idle to wait", int'(state), 1);
        wait_eval();
        chk("R4 stays at 11000", int'(state), 1);
        vbat = 16'd11001;
        wait_eval();
        chk("R4 leaves above 11000", int'(state), 2);
        wait_eval();
        chk("R5 waits for cal_done", int'(state), 2);
        meas(n);
        chk("R8 no heat while calibrating", n, 0);
        cal_done = 1'b1;
        vbat = 16'd12000;
        wait_eval();
        chk("R5 cal to condensation", int'(state), 3);
        cal_done = 1'b0;
    endtask

    task automatic t_cond();
        int n;
        int ev = 0;
        meas(n);
        chk("R6 R9 condensation duty", n, 2);
        wait_eval(); ev++;
        vbat = 16'd1800;
        meas(n);
        chk("R8 clamp low vbat", n, 100);
        vbat = 16'd12000;
        while (ev < 49) begin wait_eval(); ev++; end
        chk("R6 still condensing at 49", int'(state), 3);
        wait_eval();
        chk("R6 ramp after 50", int'(state), 4);
    endtask

    task automatic t_ramp();
        int n;
        int ev = 0;
        meas(n);
        chk("R7 ramp start duty", n, 50);
        chk("R10 not valid in ramp", int'(valid), 0);
        while (ev < 10) begin wait_eval(); ev++; end
        meas(n);
        chk("R7 ramp slope duty", n, 55);
        while (ev < 113) begin wait_eval(); ev++; end
        chk("R7 still ramping at 113", int'(state), 4);
        meas(n);
        chk("R7 R8 ramp end clamped", n, 100);
        wait_eval();
        chk("R7 regulation at 114", int'(state), 5);
        chk("R10 valid in regulation", int'(valid), 1);
    endtask

    task automatic t_reg();
        int n;
        reg_duty = 7'd37;
        meas(n);
        chk("R11 regulator duty", n, 37);
        reg_duty = 7'd127;
        meas(n);
        chk("R11 regulator clamp", n, 100);
    endtask

    task automatic t_fault();
        int n;
        fault = 1'b1;
        @(negedge clk);
        fault = 1'b0;
        chk("R12 error from regulation", int'(state), 7);
        chk("R12 heater off", int'(heater), 0);
        chk("R10 invalid in error", int'(valid), 0);
        wait_eval(); wait_eval();
        chk("R13 error holds", int'(state), 7);
        meas(n);
        chk("R12 no heat in error", n, 0);
        restart = 1'b1; fault = 1'b1;
        @(negedge clk);
        restart = 1'b0; fault = 1'b0;
        chk("R13 restart beats fault", int'(state), 0);
        repeat (3) @(negedge clk);
        fault = 1'b1;
        @(negedge clk);
        fault = 1'b0;
        chk("R12 error from idle undecimated", int'(state), 7);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk("R13 restart to idle", int'(state), 0);
        wait_eval();
        chk("R2 sequence resumes", int'(state), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wake();
        t_cond();
        t_ramp();
        t_reg();
        t_fault();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule